// File: doc/BRIEF.md
# Bang-Bang Delay-Line Regulation Controller

This block is the digital half of a delay-locked line that serves as a time-to-digital converter. A one-bit phase decision arrives from an external set-reset flip-flop. The decision says whether the delayed edge arrives early, which means the cell delay is too short, or late. The controller integrates that decision into a 6-bit fine code that drives a current-steering bias DAC. It also keeps a 3-bit thermometer code that switches equal capacitors onto every delay cell. When the fine integrator runs past either end of its range, the capacitor code takes one step and the fine code restarts from mid-scale.

The controller is clocked from the fast oscillator clock but changes state only on every eighth edge, so its logic runs at one eighth of the oscillator rate. Each sampled decision waits in a register for one update period before it moves the integrator. Because of this added latency, and because the decision has only one bit, the loop never settles on a fixed code. At lock, the fine code circles a small fixed pattern around the target.

Top module: `dll_bias_ctrl`

## Requirements
- R1: While reset (synchronous, active high) is asserted on a clock edge, the fine code becomes 32 (mid-scale) and the capacitor code becomes 3'b000.
- R2: Counting clock edges after reset is released, an update happens on edges 8, 16, 24 and so on. The fine and capacitor codes change only on an update edge.
- R3: At an update, a pending decision of 1 (cell too fast) lowers the fine code by one, and a pending decision of 0 raises it by one, except at the range ends covered by R5 to R7.
- R4: Each update samples the decision input as the new pending decision and applies the one captured at the previous update. The first update after reset captures a decision and leaves both codes unchanged.
- R5: A pending decision of 1 applied while the fine code is 0 and fewer than three capacitors are on switches one more capacitor on and reloads the fine code to 32 in the same update.
- R6: A pending decision of 0 applied while the fine code is 63 and at least one capacitor is on switches one capacitor off and reloads the fine code to 32 in the same update.
- R7: With all three capacitors on, a decision of 1 at fine code 0 leaves both codes unchanged. With none on, a decision of 0 at fine code 63 leaves both codes unchanged.
- R8: The capacitor code is always a thermometer value: bit 0 is the first capacitor switched on, and only 3'b000, 3'b001, 3'b011 and 3'b111 occur.
- R9: In a loop closed around a delay that grows with the capacitor count and shrinks as the fine code rises, the locked fine code repeats every 6 updates and swings over 3 codes from lowest to highest.
- R10: Reset asserted in the middle of operation restores the state given in R1, and R4 then applies again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oscillator clock; state changes on one edge in eight |
| rst | input | 1 | Synchronous active-high reset |
| pd_slow | input | 1 | Phase decision: 1 means the line delay is shorter than target |
| fine_code | output | 6 | Fine bias code for the current-steering DAC |
| cap_therm | output | 3 | Thermometer code of switched capacitors per cell |

## Verification
Two things can happen on the same update edge. The integrator can run off the end of its range, and the capacitor stepper can move, which forces the fine code back to mid-scale at the same moment. The bench provokes this by holding the decision constant for hundreds of updates in each direction, so the fine code wraps toward the capacitor code three times and then meets saturation. On each clock it compares the reload value and the capacitor step against a behavioural model. The pending-decision register also captures a new sample on the very edge where it releases the old one. Decision patterns that flip at every update, and a closed loop around a modelled delay, show that the two are kept one update apart.

// File: rtl/dll_ctrl_pkg.sv
package dll_ctrl_pkg;

    localparam int FINE_BITS = 6;
    localparam int CAP_CELLS = 3;
    localparam int TICK_DIV  = 8;

    typedef enum logic [1:0] {
        CAP_KEEP = 2'd0,
        CAP_ADD  = 2'd1,
        CAP_DROP = 2'd2
    } cap_req_e;

    typedef struct packed {
        logic valid;
        logic slow;
    } pd_sample_t;

endpackage

// File: rtl/dll_tick_div.sv
module dll_tick_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/dll_decision_reg.sv
module dll_decision_reg
    import dll_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       pd_in,
    output pd_sample_t dec
);
    always_ff @(posedge clk) begin
        if (rst)       dec <= '0;
        else if (tick) dec <= '{valid: 1'b1, slow: pd_in};
    end
endmodule

// File: rtl/dll_fine_integ.sv
module dll_fine_integ
    import dll_ctrl_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  pd_sample_t   dec,
    input  logic         cap_full,
    input  logic         cap_empty,
    output logic [W-1:0] fine,
    output cap_req_e     req
);
    localparam logic [W-1:0] MID = W'(1) << (W - 1);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] fine_q, fine_d;

    always_comb begin
        fine_d = fine_q;
        req    = CAP_KEEP;
        if (tick && dec.valid) begin
            if (dec.slow) begin
                if (fine_q == '0) begin
                    if (!cap_full) begin
                        req    = CAP_ADD;
                        fine_d = MID;
                    end
                end else begin
                    fine_d = fine_q - 1'b1;
                end
            end else begin
                if (fine_q == TOP) begin
                    if (!cap_empty) begin
                        req    = CAP_DROP;
                        fine_d = MID;
                    end
                end else begin
                    fine_d = fine_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fine_q <= MID;
        else     fine_q <= fine_d;
    end

    assign fine = fine_q;
endmodule

// File: rtl/dll_coarse_therm.sv
module dll_coarse_therm
    import dll_ctrl_pkg::*;
#(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  cap_req_e     req,
    output logic [N-1:0] cap,
    output logic         full,
    output logic         empty
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic up_src, dn_src;
        if (i == 0) begin : g_first
            assign up_src = 1'b1;
        end else begin : g_rest
            assign up_src = cap[i-1];
        end
        if (i == N - 1) begin : g_last
            assign dn_src = 1'b0;
        end else begin : g_body
            assign dn_src = cap[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst) cap[i] <= 1'b0;
            else begin
                case (req)
                    CAP_ADD:  cap[i] <= up_src;
                    CAP_DROP: cap[i] <= dn_src;
                    default:  cap[i] <= cap[i];
                endcase
            end
        end
    end

    assign full  = cap[N-1];
    assign empty = ~cap[0];
endmodule

// File: rtl/dll_bias_ctrl.sv
module dll_bias_ctrl
    import dll_ctrl_pkg::*;
#(
    parameter int FINE_W = FINE_BITS,
    parameter int CAP_N  = CAP_CELLS,
    parameter int DIV    = TICK_DIV
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_slow,
    output logic [FINE_W-1:0] fine_code,
    output logic [CAP_N-1:0]  cap_therm
);
    logic       tick;
    pd_sample_t dec;
    logic       cap_full, cap_empty;
    cap_req_e   req;

    dll_tick_div #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dll_decision_reg u_dec (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .pd_in (pd_slow),
        .dec   (dec)
    );

    dll_fine_integ #(.W(FINE_W)) u_fine (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .dec       (dec),
        .cap_full  (cap_full),
        .cap_empty (cap_empty),
        .fine      (fine_code),
        .req       (req)
    );

    dll_coarse_therm #(.N(CAP_N)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .cap   (cap_therm),
        .full  (cap_full),
        .empty (cap_empty)
    );
endmodule

// File: rtl/dll_bias_ctrl_chk.sv
module dll_bias_ctrl_chk
    import dll_ctrl_pkg::*;
#(
    parameter int W = 6,
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input pd_sample_t   dec,
    input logic [W-1:0] fine,
    input logic [N-1:0] cap
);
    localparam logic [W-1:0] MID = W'(1) << (W - 1);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    p_quiet_between_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(fine) && $stable(cap)));

    p_first_update_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !dec.valid) |=> ($stable(fine) && $stable(cap)));

    p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && dec.valid && dec.slow && fine != '0) |=> (fine == $past(fine) - 1'b1));

    p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && dec.valid && !dec.slow && fine != TOP) |=> (fine == $past(fine) + 1'b1));

    p_add_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && dec.valid && dec.slow && fine == '0 && !cap[N-1])
        |=> (fine == MID && cap == {$past(cap[N-2:0]), 1'b1}));

    p_drop_reload_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && dec.valid && !dec.slow && fine == TOP && cap[0])
        |=> (fine == MID && cap == {1'b0, $past(cap[N-1:1])}));

    p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && dec.valid && ((dec.slow && fine == '0 && cap[N-1]) ||
                               (!dec.slow && fine == TOP && !cap[0])))
        |=> ($stable(fine) && $stable(cap)));

    p_thermometer_r8: assert property (@(posedge clk) disable iff (rst)
        (cap & (cap + N'(1))) == '0);
endmodule

bind dll_bias_ctrl dll_bias_ctrl_chk #(.W(FINE_W), .N(CAP_N)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .dec  (dec),
    .fine (fine_code),
    .cap  (cap_therm)
);

// File: tb/tb_dll_bias_ctrl.sv
module tb_dll_bias_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pd_slow = 1'b0;
    logic [5:0] fine_code;
    logic [2:0] cap_therm;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_n = 0;
    bit done  = 1'b0;

    // behavioural reference state
    int m_cnt = 0;
    int m_fine = 32;
    int m_caps = 0;
    bit m_dv = 1'b0;
    bit m_dq = 1'b0;
    bit m_tick = 1'b0;

    int prev_fine = 32;
    int prev_cap = 0;
    int adds = 0;
    int drops = 0;

    int hist[$];

    dll_bias_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .pd_slow   (pd_slow),
        .fine_code (fine_code),
        .cap_therm (cap_therm)
    );

    always #10 clk = ~clk;

    function automatic int therm(int n);
        return (1 << n) - 1;
    endfunction

    function automatic bit closed_pd();
        // delay units: base 100, +40 per capacitor, -1 per fine code; target 120.5
        return (2 * (100 + 40 * m_caps - m_fine)) < 241;
    endfunction

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_edge(bit p);
        m_tick = 1'b0;
        if (rst) begin
            m_cnt = 0; m_fine = 32; m_caps = 0; m_dv = 1'b0; m_dq = 1'b0;
        end else begin
            m_tick = (m_cnt == 7);
            m_cnt  = (m_cnt + 1) % 8;
            if (m_tick) begin
                if (m_dv) begin
                    if (m_dq) begin
                        if (m_fine == 0) begin
                            if (m_caps < 3) begin m_caps++; m_fine = 32; end
                        end else m_fine--;
                    end else begin
                        if (m_fine == 63) begin
                            if (m_caps > 0) begin m_caps--; m_fine = 32; end
                        end else m_fine++;
                    end
                end
                m_dq = p;
                m_dv = 1'b1;
            end
        end
    endtask

    // one clock: drive at negedge, model after posedge, compare at next negedge
    task automatic cyc(bit p);
        pd_slow = p;
        @(posedge clk);
        model_edge(p);
        @(negedge clk);
        chk(fine_code == m_fine, "R3 fine code vs model", fine_code, m_fine);
        chk(cap_therm == therm(m_caps), "R5/R6 capacitor code vs model", cap_therm, therm(m_caps));
        chk(cap_therm == 3'b000 || cap_therm == 3'b001 || cap_therm == 3'b011 || cap_therm == 3'b111,
            "R8 thermometer form", cap_therm, therm(m_caps));
        if (!rst && !m_tick) begin
            chk(fine_code == prev_fine && cap_therm == prev_cap, "R2 no change off update",
                fine_code, prev_fine);
        end
        if (!rst && cap_therm != prev_cap) begin
            if (cap_therm > prev_cap) adds++; else drops++;
            chk(fine_code == 32, "R5/R6 reload to mid-scale", fine_code, 32);
        end
        prev_fine = fine_code;
        prev_cap  = cap_therm;
    endtask

    task automatic updates(int n, bit p);
        repeat (n * 8) cyc(p);
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 150000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_n, 150000);
            report();
        end
    end

    initial begin
        int lo, hi;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) cyc(1'b0);
        rst = 1'b0;
        prev_fine = fine_code;
        prev_cap  = cap_therm;
        chk(fine_code == 32, "R1 reset fine", fine_code, 32);
        chk(cap_therm == 3'b000, "R1 reset capacitors", cap_therm, 0);

        // first update after reset only captures (R4)
        updates(1, 1'b1);
        chk(fine_code == 32, "R4 first update idle", fine_code, 32);
        updates(1, 1'b1);
        chk(fine_code == 31, "R3 decision 1 lowers code", fine_code, 31);
        updates(1, 1'b0);
        chk(fine_code == 30, "R4 previous decision applied", fine_code, 30);
        updates(1, 1'b1);
        chk(fine_code == 31, "R4 decision 0 applied one update late", fine_code, 31);

        // alternating decisions
        for (int k = 0; k < 20; k++) updates(1, k[0]);
        chk(fine_code >= 29 && fine_code <= 32, "R3 alternating stays near", fine_code, 31);

        // long run of decision 1: three capacitor adds then saturation
        adds = 0;
        updates(300, 1'b1);
        chk(adds == 3, "R5 capacitor adds", adds, 3);
        chk(cap_therm == 3'b111, "R7 saturate full capacitors", cap_therm, 7);
        chk(fine_code == 0, "R7 fine held at bottom", fine_code, 0);

        // long run of decision 0: three drops then saturation
        drops = 0;
        updates(300, 1'b0);
        chk(drops == 3, "R6 capacitor drops", drops, 3);
        chk(cap_therm == 3'b000, "R7 saturate empty", cap_therm, 0);
        chk(fine_code == 63, "R7 fine held at top", fine_code, 63);

        // mid-run reset
        repeat (3) cyc(1'b1);
        rst = 1'b1;
        repeat (2) cyc(1'b1);
        rst = 1'b0;
        prev_fine = fine_code;
        prev_cap  = cap_therm;
        chk(fine_code == 32 && cap_therm == 3'b000, "R10 mid-run reset", fine_code, 32);
        updates(1, 1'b1);
        chk(fine_code == 32, "R10 first update idle again", fine_code, 32);

        // closed loop around a behavioural delay line
        for (int k = 0; k < 250 * 8; k++) cyc(closed_pd());
        chk(cap_therm == 3'b001, "R9 locked with one capacitor", cap_therm, 1);
        while (hist.size() < 48) begin
            cyc(closed_pd());
            if (m_tick) hist.push_back(fine_code);
        end
        lo = 63; hi = 0;
        foreach (hist[i]) begin
            if (hist[i] < lo) lo = hist[i];
            if (hist[i] > hi) hi = hist[i];
        end
        chk(hi - lo == 3, "R9 limit-cycle swing", hi - lo, 3);
        for (int i = 0; i + 6 < 48; i++)
            chk(hist[i] == hist[i+6], "R9 limit-cycle period six", hist[i+6], hist[i]);
        chk(hist[0] != hist[3] || hist[1] != hist[4], "R9 not period three", hist[3], -1);

        done = 1'b1;
        report();
    end
endmodule